// File: doc/BRIEF.md
# Multi-Master I2C Arbitrating Byte Transmitter

This block is the bit-level send stage of an I2C controller that shares the bus with other masters. It takes one byte at a time over a valid/ready handshake and places it on an open-drain SDA line, most significant bit first. A 0 pulls the line low and a 1 releases it. An external clock generator supplies two strobes: one when SCL has gone low, and one when SCL is high. The block changes SDA only on the low strobe. It reads the line back on the high strobe.

If the block releases the line for a 1 but reads back a 0, another master is driving the bus, and this block has lost arbitration. From then on it stops driving SDA for the rest of the byte. It still steps through every remaining clock up to the ninth, so the surrounding controller can keep producing clock pulses. If the byte was flagged as an address, the loss also raises a request to turn into a slave, because the winning master may be addressing this device. On the ninth clock the block always releases SDA and records the acknowledge level driven by the receiver.

Back-pressure: a byte is taken in the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole nine-clock frame and rises in the same cycle as the `byte_done` pulse. The data and the address flag are only sampled in the accept cycle. A source may hold `tx_valid` high for any length of time.

Top module: `i2c_arb_tx`

## Requirements
- R1: After reset, `sda_drive_low`, `arb_lost`, `slave_req`, `byte_done` and `ack_rx` are 0, and `tx_ready` is 1.
- R2: A byte is accepted when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` is then 0 from the next cycle, and it returns to 1 in the cycle after the ninth accepted high strobe.
- R3: At the k-th accepted low strobe, for k = 1 to 8, `sda_drive_low` updates in the next cycle. It becomes 1 exactly when data bit 8-k (bit 7 first) is 0 and `arb_lost` is 0, and it holds that value until the next accepted low strobe.
- R4: At the ninth accepted low strobe, `sda_drive_low` becomes 0, so SDA is released for the acknowledge.
- R5: `sda_drive_low` changes only in the cycle after an accepted low strobe, so SDA never moves during SCL high.
- R6: At an accepted high strobe for bits 1 to 8, `arb_lost` rises in the next cycle exactly when the current bit is 1, `sda_in` is 0, and arbitration was not already lost. A bit of 0, or a matching line level, never causes a loss.
- R7: After a loss, `sda_drive_low` stays 0 for the remaining bits. The block still counts all nine clocks and still pulses `byte_done`.
- R8: `arb_lost` stays 1 until the next byte is accepted, and it clears in the cycle after that accept.
- R9: `slave_req` rises together with `arb_lost` only when the byte's `tx_addr` flag was 1 at accept. It clears on the next accept.
- R10: `byte_done` is a one-cycle pulse in the cycle after the ninth accepted high strobe. In that same cycle, `ack_rx` shows 1 if `sda_in` was low at that strobe (ACK) and 0 if it was high (NACK). `ack_rx` holds this value until the next ninth strobe.
- R11: Strobes while idle have no effect. A high strobe is accepted only after that bit's low strobe. A low strobe is accepted only once per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block idle and able to take a byte |
| tx_data | input | 8 | Byte to send, bit 7 first |
| tx_addr | input | 1 | Byte is an address (loss requests slave mode) |
| scl_low_stb | input | 1 | One-cycle strobe: SCL is low, SDA may change |
| scl_high_stb | input | 1 | One-cycle strobe: SCL is high, sample SDA |
| sda_in | input | 1 | Synchronised SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| arb_lost | output | 1 | Arbitration lost, sticky until next accept |
| slave_req | output | 1 | Loss happened on an address byte |
| byte_done | output | 1 | One-cycle pulse after the ninth clock |
| ack_rx | output | 1 | 1 = ACK, 0 = NACK on the last ninth clock |

## Verification
Every output is registered, so each result is due exactly one cycle after the edge that takes its stimulus:
- `sda_drive_low` follows an accepted low strobe.
- `arb_lost`, `slave_req`, `byte_done` and `ack_rx` follow an accepted high strobe.
- `tx_ready` follows an accept or the ninth high strobe.

The bench keeps a behavioural model that sees the same inputs at each rising edge and updates its expectations there. It compares all outputs on the following falling edge, which is the first point where a one-cycle latency becomes visible. Stimulus changes only on falling edges. Directed checks are placed in the same way: after an accept, after the ninth low strobe, after a lost byte, and after strobes given while idle.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  // Which strobe the current bit is waiting for
  typedef enum logic {
    PH_WAIT_LOW  = 1'b0,
    PH_WAIT_HIGH = 1'b1
  } bit_phase_e;
endpackage

// File: rtl/i2c_arb_seq.sv
module i2c_arb_seq
  import i2c_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic low_stb,
  input  logic high_stb,
  output logic busy,
  output logic drive_ev,
  output logic samp_ev,
  output logic ack_slot,
  output logic byte_done
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] idx;
  bit_phase_e       phase;

  assign ack_slot = (idx == CNT_W'(DATA_W));
  assign drive_ev = busy & low_stb  & (phase == PH_WAIT_LOW);
  assign samp_ev  = busy & high_stb & (phase == PH_WAIT_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      phase     <= PH_WAIT_LOW;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        idx   <= '0;
        phase <= PH_WAIT_LOW;
      end else if (drive_ev) begin
        phase <= PH_WAIT_HIGH;
      end else if (samp_ev) begin
        phase <= PH_WAIT_LOW;
        if (ack_slot) begin
          busy      <= 1'b0;
          byte_done <= 1'b1;
        end else begin
          idx <= idx + CNT_W'(1);
        end
      end
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !busy);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> ($stable(idx) && !busy));
endmodule

// File: rtl/i2c_arb_shreg.sv
module i2c_arb_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              shift,
  output logic              tx_bit
);
  logic [DATA_W-1:0] sreg;

  assign tx_bit = sreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= data_in;
    else if (shift) sreg <= {sreg[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/i2c_arb_judge.sv
module i2c_arb_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic addr_in,
  input  logic drive_ev,
  input  logic samp_ev,
  input  logic ack_slot,
  input  logic tx_bit,
  input  logic sda_in,
  output logic sda_drive_low,
  output logic arb_lost,
  output logic slave_req,
  output logic ack_rx
);
  logic is_addr;
  logic lose_now;

  // released line for a 1 but the bus reads 0
  assign lose_now = samp_ev & ~ack_slot & ~arb_lost & tx_bit & ~sda_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_drive_low <= 1'b0;
      arb_lost      <= 1'b0;
      slave_req     <= 1'b0;
      ack_rx        <= 1'b0;
      is_addr       <= 1'b0;
    end else begin
      if (load) begin
        arb_lost  <= 1'b0;
        slave_req <= 1'b0;
        is_addr   <= addr_in;
      end else if (lose_now) begin
        arb_lost      <= 1'b1;
        slave_req     <= is_addr;
        sda_drive_low <= 1'b0;
      end
      if (drive_ev)
        sda_drive_low <= ~ack_slot & ~tx_bit & ~arb_lost;
      if (samp_ev && ack_slot)
        ack_rx <= ~sda_in;
    end
  end

  // R5
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(drive_ev));
  // R7
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !sda_drive_low);
  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> $past(load));
  // R9
  slave_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_req |-> arb_lost);
endmodule

// File: rtl/i2c_arb_tx.sv
module i2c_arb_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  input  logic              scl_low_stb,
  input  logic              scl_high_stb,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic              arb_lost,
  output logic              slave_req,
  output logic              byte_done,
  output logic              ack_rx
);
  logic busy, load, drive_ev, samp_ev, ack_slot, tx_bit;

  assign tx_ready = ~busy;
  assign load     = tx_valid & ~busy;

  i2c_arb_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .low_stb(scl_low_stb), .high_stb(scl_high_stb),
    .busy(busy), .drive_ev(drive_ev), .samp_ev(samp_ev),
    .ack_slot(ack_slot), .byte_done(byte_done)
  );

  i2c_arb_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .data_in(tx_data),
    .shift(samp_ev & ~ack_slot), .tx_bit(tx_bit)
  );

  i2c_arb_judge u_judge (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(tx_addr),
    .drive_ev(drive_ev), .samp_ev(samp_ev), .ack_slot(ack_slot),
    .tx_bit(tx_bit), .sda_in(sda_in),
    .sda_drive_low(sda_drive_low), .arb_lost(arb_lost),
    .slave_req(slave_req), .ack_rx(ack_rx)
  );

  // R2
  ready_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_ready);
  // R6
  loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(!sda_in) && $past(scl_high_stb) && !$past(sda_drive_low)));
endmodule

// File: tb/test_i2c_arb_tx.sv
module test_i2c_arb_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_addr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_low_stb = 1'b0, scl_high_stb = 1'b0, other_low = 1'b0;
  logic sda_in, tx_ready, sda_drive_low, arb_lost, slave_req, byte_done, ack_rx;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;

  always #4 clk = ~clk;

  // wired-AND bus: either master pulling low makes the line low
  assign sda_in = ~(sda_drive_low | other_low);

  i2c_arb_tx i_i2c_arb_tx (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_addr(tx_addr), .scl_low_stb(scl_low_stb),
    .scl_high_stb(scl_high_stb), .sda_in(sda_in), .sda_drive_low(sda_drive_low),
    .arb_lost(arb_lost), .slave_req(slave_req), .byte_done(byte_done), .ack_rx(ack_rx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_busy, m_step, m_seen, m_lost, m_slave, m_addr, e_drv, e_done, e_ack;
  int m_bits[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_step = 0; m_seen = 0; m_lost = 0; m_slave = 0;
      m_addr = 0; e_drv = 0; e_done = 0; e_ack = 0;
    end else begin
      e_done = 0;
      if (m_busy == 0) begin
        if (tx_valid) begin
          m_busy = 1; m_step = 0; m_seen = 0; m_lost = 0; m_slave = 0;
          m_addr = int'(tx_addr);
          for (int i = 0; i < 8; i++) m_bits[i] = int'(tx_data[7-i]);
        end
      end else if (scl_low_stb && m_seen == 0) begin
        m_seen = 1;
        e_drv = (m_step < 8 && m_lost == 0 && m_bits[m_step % 8] == 0) ? 1 : 0;
      end else if (scl_high_stb && m_seen == 1) begin
        m_seen = 0;
        if (m_step < 8) begin
          if (m_bits[m_step] == 1 && m_lost == 0 && sda_in == 1'b0) begin
            m_lost = 1;
            if (m_addr == 1) m_slave = 1;
          end
          m_step++;
        end else begin
          e_ack = sda_in ? 0 : 1;
          e_done = 1;
          m_busy = 0;
        end
      end
    end
  end

  // compare on every falling edge, one half cycle after the updates
  logic prev_drv = 1'b0;
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_ready == (m_busy == 0), "R2 tx_ready", int'(tx_ready), int'(m_busy == 0));
      chk(int'(sda_drive_low) == e_drv, "R3 sda_drive_low", int'(sda_drive_low), e_drv);
      chk(int'(arb_lost) == m_lost, "R6 arb_lost", int'(arb_lost), m_lost);
      chk(int'(slave_req) == m_slave, "R9 slave_req", int'(slave_req), m_slave);
      chk(int'(byte_done) == e_done, "R10 byte_done", int'(byte_done), e_done);
      chk(int'(ack_rx) == e_ack, "R10 ack_rx", int'(ack_rx), e_ack);
      chk(sda_drive_low == prev_drv || prev_low, "R5 drive moved without low strobe",
          int'(sda_drive_low), int'(prev_drv));
      if (byte_done) done_seen++;
    end
    prev_drv = sda_drive_low;
    prev_low = scl_low_stb;
  end

  // ---------------- stimulus ----------------
  task automatic one_bit(input logic oth, input bit is_ack);
    @(negedge clk); other_low = oth; scl_low_stb = 1'b1;
    @(negedge clk); scl_low_stb = 1'b0;
    if (is_ack) chk(sda_drive_low == 1'b0, "R4 released on ninth clock", int'(sda_drive_low), 0);
    @(negedge clk); scl_high_stb = 1'b1;
    @(negedge clk); scl_high_stb = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic a, input logic [7:0] rival,
                      input logic ack, input bit early_high);
    @(negedge clk); tx_valid = 1'b1; tx_data = d; tx_addr = a;
    @(negedge clk); tx_valid = 1'b0;
    chk(arb_lost == 1'b0, "R8 lost cleared by accept", int'(arb_lost), 0);
    if (early_high) begin
      scl_high_stb = 1'b1;
      @(negedge clk); scl_high_stb = 1'b0;
    end
    for (int i = 7; i >= 0; i--) one_bit(~rival[i], 1'b0);
    one_bit(ack, 1'b1);
    @(negedge clk); other_low = 1'b0;
  endtask

  task automatic idle_strobes();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); scl_low_stb = 1'b1; other_low = 1'b1;
      @(negedge clk); scl_low_stb = 1'b0; scl_high_stb = 1'b1;
      @(negedge clk); scl_high_stb = 1'b0; other_low = 1'b0;
    end
    @(negedge clk);
    chk(sda_drive_low == 1'b0, "R11 idle strobes no drive", int'(sda_drive_low), 0);
    chk(tx_ready == 1'b1, "R11 idle strobes stay ready", int'(tx_ready), 1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1 && sda_drive_low == 1'b0 && arb_lost == 1'b0 &&
        slave_req == 1'b0 && byte_done == 1'b0 && ack_rx == 1'b0,
        "R1 reset state", int'({tx_ready, sda_drive_low, arb_lost, slave_req, byte_done, ack_rx}), 32);

    idle_strobes();                               // R11 while idle
    send(8'hA5, 1'b0, 8'hFF, 1'b1, 1'b0);         // R3 plain byte, ACK
    chk(ack_rx == 1'b1, "R10 ack seen", int'(ack_rx), 1);
    send(8'h3C, 1'b0, 8'hFF, 1'b0, 1'b1);         // R11 early high, NACK
    chk(ack_rx == 1'b0, "R10 nack seen", int'(ack_rx), 0);

    d0 = done_seen;
    send(8'h50, 1'b1, 8'h48, 1'b1, 1'b0);         // address loss
    chk(arb_lost == 1'b1, "R6 address loss", int'(arb_lost), 1);
    chk(slave_req == 1'b1, "R9 slave on address loss", int'(slave_req), 1);
    chk(done_seen == d0 + 1, "R7 done after loss", done_seen, d0 + 1);
    idle_strobes();
    chk(arb_lost == 1'b1, "R8 lost held while idle", int'(arb_lost), 1);

    send(8'hFF, 1'b0, 8'hFE, 1'b0, 1'b0);         // data loss on last bit
    chk(arb_lost == 1'b1, "R6 data loss", int'(arb_lost), 1);
    chk(slave_req == 1'b0, "R9 no slave on data loss", int'(slave_req), 0);

    send(8'h5A, 1'b1, 8'h5A, 1'b1, 1'b0);         // identical rival byte
    chk(arb_lost == 1'b0, "R6 matching rival no loss", int'(arb_lost), 0);

    d0 = done_seen;
    send(8'h00, 1'b1, 8'h00, 1'b0, 1'b0);         // all zeros driven
    chk(arb_lost == 1'b0, "R6 zeros never lose", int'(arb_lost), 0);
    chk(done_seen == d0 + 1, "R10 single done pulse", done_seen, d0 + 1);

    send(8'hC3, 1'b1, 8'h03, 1'b1, 1'b0);         // loss on first bit, rest released
    chk(slave_req == 1'b1, "R7 early loss keeps counting", int'(slave_req), 1);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule